// File: doc/BRIEF.md
# T1 Line-Clock Digital PLL

This block produces a 1.544 MHz line clock that follows the falling edge of an 8 kHz frame reference. It runs on a system clock at twice the 12.352 MHz master rate, so one system tick is half a master period. A single frame phase counter covers a whole 125 µs frame: 16 ticks make one line-clock period (a divide by 8 of the master), and 193 line periods make one frame. From this counter the block derives the line clock, an internal 8 kHz square wave and a correction-enable window.

The reference goes through a two-flop synchroniser, and its falling edge is detected there. On each detected fall the block looks at the current frame phase. Inside a narrow dead band around the falling edge of the internal 8 kHz wave it does nothing. Outside the dead band it shortens the frame by one tick when the internal 8 kHz wave is high, or lengthens it by one tick when the wave is low. Because every output comes from the same counter, a correction moves all of them at the same edge. After a run of quiet frames (frames with no correction), a lock flag is raised.

Top module: `t1_line_dpll`

## Requirements
- R1: The frame phase counter steps by one each tick, from 0 to 3087, and then wraps to 0. The line clock is high while the low four phase bits are 0 to 7 and low while they are 8 to 15. With no correction, the rising edges of the line clock are exactly 16 ticks apart, and a frame holds 193 of them.
- R2: The inverted line-clock output is always the complement of the line-clock output.
- R3: The reference passes through two synchroniser flops. Suppose the first flop captures a low, after it had held a high, at edge k. The frame phase held between edges k+1 and k+2 is then the sampled phase, and any correction takes effect at edge k+2.
- R4: A sampled phase from 1540 to 1547 (the dead band, 8 ticks = 4 master periods centred on the internal 8 kHz fall at phase 1544) makes no correction.
- R5: A sampled phase below 1540 (internal 8 kHz high, window active) makes a shrink: the counter advances by two at a single edge, so one line-clock period is 15 ticks.
- R6: A sampled phase of 1548 or above (internal 8 kHz low, window active) makes a stretch: the counter holds for one extra tick, so one line-clock period is 17 ticks.
- R7: The lock flag rises at the edge that applies the 4th consecutive sample with no correction. It falls at the edge that applies a correction.
- R8: While the active-low reset is low, the counter is 0, the synchroniser flops hold low and the lock flag is 0. The line clock therefore reads 1 and its inverse reads 0. A reference that is low when reset is released produces no sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock at twice the master rate (24.704 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_frame_i | input | 1 | 8 kHz frame reference; its falling edge is tracked |
| line_clk_o | output | 1 | 1.544 MHz line clock |
| line_clk_n_o | output | 1 | Inverted line clock |
| locked_o | output | 1 | High after 4 consecutive quiet samples |

## Verification
The hardest situation to reach is a sample that lands exactly on a dead-band edge (phases 1539/1540 and 1547/1548). Hitting it needs tick-accurate control of when the reference falls relative to an internal counter that the ports do not show. The bench keeps its own arithmetic frame-phase model, starting from the known reset phase. It drops the reference exactly two ticks before the target phase, which accounts for the synchroniser delay. Whether a correction happened is then seen at the ports through the lock flag and through the 15-tick or 17-tick line-clock period around the sample.

// File: rtl/t1dpll_pkg.sv
package t1dpll_pkg;
   // how far the frame phase moves on one tick
   typedef enum logic [1:0] {
      ADV_HOLD = 2'd0,   // stretch
      ADV_ONE  = 2'd1,   // normal
      ADV_TWO  = 2'd2    // shrink
   } adv_t;
endpackage

// File: rtl/t1dpll_ref_sync.sv
module t1dpll_ref_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_i,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("t1dpll_ref_sync: STAGES must be at least 2");
   end

   // q[0..STAGES-1] synchronise, q[STAGES] is the delayed copy for edge detection
   logic [STAGES:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= {q[STAGES-1:0], ref_i};
   end

   assign fall_o = q[STAGES] & ~q[STAGES-1];

   // R3: a detected fall lasts exactly one tick
   a_r3_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);
endmodule

// File: rtl/t1dpll_phase_det.sv
module t1dpll_phase_det
   import t1dpll_pkg::*;
#(
   parameter int FRAME_TICKS    = 3088,
   parameter int DEADBAND_TICKS = 8,
   parameter int PH_W           = 12
) (
   input  logic [PH_W-1:0] ph_i,
   input  logic            fall_i,
   output adv_t            adv_o,
   output logic            corr_o
);
   localparam int HALF = FRAME_TICKS / 2;
   localparam int DB_LO = HALF - DEADBAND_TICKS / 2;
   localparam int DB_HI = HALF + DEADBAND_TICKS / 2;

   if ((DEADBAND_TICKS % 2) != 0 || DEADBAND_TICKS < 2 || DB_LO < 1) begin : g_bad_db
      $error("t1dpll_phase_det: dead band must be even and fit inside half a frame");
   end

   logic int8k;    // internal 8 kHz wave, high in first half frame
   logic win_act;  // correction window active (outside dead band)

   assign int8k   = ph_i < PH_W'(HALF);
   assign win_act = !((ph_i >= PH_W'(DB_LO)) && (ph_i < PH_W'(DB_HI)));

   always_comb begin
      adv_o  = ADV_ONE;
      corr_o = 1'b0;
      if (fall_i && win_act) begin
         corr_o = 1'b1;
         adv_o  = int8k ? ADV_TWO : ADV_HOLD;
      end
   end
endmodule

// File: rtl/t1dpll_timebase.sv
module t1dpll_timebase
   import t1dpll_pkg::*;
#(
   parameter int FRAME_TICKS    = 3088,
   parameter int TICKS_PER_LINE = 16,
   parameter int PH_W           = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  adv_t            adv_i,
   output logic [PH_W-1:0] ph_o,
   output logic            line_clk_o
);
   localparam int SUB_W = $clog2(TICKS_PER_LINE);

   logic [PH_W-1:0] ph;
   logic [PH_W:0]   sum;
   logic [PH_W-1:0] nxt;

   always_comb begin
      sum = {1'b0, ph} + (PH_W+1)'(adv_i);
      if (sum >= (PH_W+1)'(FRAME_TICKS)) nxt = PH_W'(sum - (PH_W+1)'(FRAME_TICKS));
      else                               nxt = sum[PH_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph <= '0;
      else        ph <= nxt;
   end

   assign ph_o       = ph;
   assign line_clk_o = ~ph[SUB_W-1];

   a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
      ph < PH_W'(FRAME_TICKS));
   a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i == ADV_ONE) |=> ph == PH_W'((int'($past(ph)) + 1) % FRAME_TICKS));
   a_r5_shrink: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i == ADV_TWO) |=> ph == PH_W'((int'($past(ph)) + 2) % FRAME_TICKS));
   a_r6_stretch: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i == ADV_HOLD) |=> ph == $past(ph));
endmodule

// File: rtl/t1dpll_lock.sv
module t1dpll_lock #(
   parameter int LOCK_FRAMES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fall_i,
   input  logic corr_i,
   output logic locked_o
);
   localparam int CNT_W = $clog2(LOCK_FRAMES + 1);

   if (LOCK_FRAMES < 1) begin : g_bad_lock
      $error("t1dpll_lock: LOCK_FRAMES must be at least 1");
   end

   logic [CNT_W-1:0] quiet;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) quiet <= '0;
      else if (fall_i) begin
         if (corr_i)                            quiet <= '0;
         else if (quiet != CNT_W'(LOCK_FRAMES)) quiet <= quiet + 1'b1;
      end
   end

   assign locked_o = (quiet == CNT_W'(LOCK_FRAMES));

   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_i && corr_i) |=> !locked_o);
   a_r7_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_o) |-> ($past(fall_i) && !$past(corr_i)));
   a_r7_steady: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_i |=> $stable(locked_o));
endmodule

// File: rtl/t1_line_dpll.sv
module t1_line_dpll
   import t1dpll_pkg::*;
#(
   parameter int TICKS_PER_LINE  = 16,
   parameter int LINES_PER_FRAME = 193,
   parameter int DEADBAND_TICKS  = 8,
   parameter int LOCK_FRAMES     = 4,
   parameter int SYNC_STAGES     = 2
) (
   input  logic clk_sys,
   input  logic rst_n,
   input  logic ref_frame_i,
   output logic line_clk_o,
   output logic line_clk_n_o,
   output logic locked_o
);
   localparam int FRAME_TICKS = TICKS_PER_LINE * LINES_PER_FRAME;
   localparam int PH_W        = $clog2(FRAME_TICKS);

   if (TICKS_PER_LINE < 4 || (TICKS_PER_LINE & (TICKS_PER_LINE - 1)) != 0) begin : g_bad_tpl
      $error("t1_line_dpll: TICKS_PER_LINE must be a power of two, at least 4");
   end
   if (DEADBAND_TICKS >= FRAME_TICKS / 2) begin : g_bad_band
      $error("t1_line_dpll: dead band wider than half a frame");
   end

   logic            fall;
   logic            corr;
   adv_t            adv;
   logic [PH_W-1:0] ph;
   logic            lclk;

   t1dpll_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk_sys), .rst_n(rst_n), .ref_i(ref_frame_i), .fall_o(fall)
   );

   t1dpll_phase_det #(
      .FRAME_TICKS(FRAME_TICKS), .DEADBAND_TICKS(DEADBAND_TICKS), .PH_W(PH_W)
   ) u_det (
      .ph_i(ph), .fall_i(fall), .adv_o(adv), .corr_o(corr)
   );

   t1dpll_timebase #(
      .FRAME_TICKS(FRAME_TICKS), .TICKS_PER_LINE(TICKS_PER_LINE), .PH_W(PH_W)
   ) u_tb (
      .clk(clk_sys), .rst_n(rst_n), .adv_i(adv), .ph_o(ph), .line_clk_o(lclk)
   );

   t1dpll_lock #(.LOCK_FRAMES(LOCK_FRAMES)) u_lock (
      .clk(clk_sys), .rst_n(rst_n), .fall_i(fall), .corr_i(corr), .locked_o(locked_o)
   );

   assign line_clk_o   = lclk;
   assign line_clk_n_o = ~lclk;

   // R8: outputs at their reset values while reset is held
   always_comb begin
      if (!rst_n) a_r8_reset_outputs: assert (lclk && !locked_o);
   end
endmodule

// File: tb/t1_line_dpll_test.sv
`timescale 1ns/1ps
module t1_line_dpll_test;
   localparam int TPL   = 16;
   localparam int LPF   = 193;
   localparam int FR    = TPL * LPF;
   localparam int HALF  = FR / 2;
   localparam int DB_LO = HALF - 4;
   localparam int DB_HI = HALF + 4;
   localparam int LK    = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_frame = 1'b0;
   logic line_clk, line_clk_n, locked;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   string ctag = "R8";

   t1_line_dpll uut (
      .clk_sys(clk), .rst_n(rst_n), .ref_frame_i(ref_frame),
      .line_clk_o(line_clk), .line_clk_n_o(line_clk_n), .locked_o(locked)
   );

   always #2.5 clk = ~clk;

   // arithmetic model of the frame phase, synchroniser and quiet-frame count
   int mph = 0;
   int mq  = 0;
   int cyc = 0;
   logic m1 = 0, m2 = 0, m3 = 0;
   always @(posedge clk) begin
      cyc = cyc + 1;
      if (!rst_n) begin
         mph = 0; mq = 0; m1 = 0; m2 = 0; m3 = 0;
      end else begin
         int step;
         step = 1;
         if (m3 && !m2) begin
            if (mph >= DB_LO && mph < DB_HI) begin
               if (mq < LK) mq = mq + 1;
            end else begin
               mq = 0;
               step = (mph < HALF) ? 2 : 0;
            end
         end
         mph = (mph + step) % FR;
         m3 = m2; m2 = m1; m1 = ref_frame;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         if (fails < 25) $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // continuous comparison against the model, away from the clock edge
   always @(negedge clk) begin
      if (!done) begin
         int e;
         e = ((mph % TPL) < TPL / 2) ? 1 : 0;
         check(line_clk == e[0], {ctag, " line clock (R1)"}, line_clk, e);
         check(line_clk_n == ~line_clk, "R2 inverse", line_clk_n, !line_clk);
         check(locked == (mq >= LK), {ctag, " lock (R7)"}, locked, mq >= LK);
      end
   end

   // rising-edge interval monitor
   logic prev_lc = 1'b0;
   bit   have_rise = 1'b0;
   int   lastc = 0, imin = 1000, imax = 0, rises = 0;
   always @(negedge clk) begin
      if (line_clk && !prev_lc) begin
         if (have_rise) begin
            if (cyc - lastc < imin) imin = cyc - lastc;
            if (cyc - lastc > imax) imax = cyc - lastc;
         end
         have_rise = 1'b1;
         lastc = cyc;
         rises++;
      end
      prev_lc = line_clk;
   end

   task automatic clear_mon();
      have_rise = 1'b0; imin = 1000; imax = 0; rises = 0;
   endtask

   // R3: drop the reference so that the sampled phase is exactly t
   task automatic drop_at(input int t);
      int w;
      w = (t - 2 + FR) % FR;
      clear_mon();
      do @(negedge clk); while (mph != w);
      ref_frame = 1'b0;
      repeat (300) @(negedge clk);
      ref_frame = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      // R8: reset state, reference low across release
      repeat (10) @(negedge clk);
      check(line_clk == 1'b1, "R8 line clock in reset", line_clk, 1);
      check(line_clk_n == 1'b0, "R8 inverse in reset", line_clk_n, 0);
      check(locked == 1'b0, "R8 lock in reset", locked, 0);
      rst_n = 1'b1;
      repeat (40) @(negedge clk);
      ref_frame = 1'b1;
      repeat (10) @(negedge clk);
      check(locked == 1'b0, "R8 no sample from low ref at release", locked, 0);

      // R1: free-running frame
      ctag = "R1";
      clear_mon();
      repeat (FR) @(negedge clk);
      check(rises == LPF, "R1 rises per frame", rises, LPF);
      check(imin == TPL, "R1 min period", imin, TPL);
      check(imax == TPL, "R1 max period", imax, TPL);

      // R4 + R7: quiet frames build lock
      ctag = "R7";
      for (int i = 1; i <= LK; i++) begin
         drop_at(HALF);
         check(imin == TPL && imax == TPL, "R4 no correction at centre", imin, TPL);
         check(locked == (i >= LK), "R7 lock after quiet frames", locked, i >= LK);
      end

      // R3/R4: dead band edges inside
      ctag = "R3";
      drop_at(DB_LO);
      check(locked == 1'b1, "R4 low band edge quiet", locked, 1);
      check(imin == TPL, "R4 low band edge period", imin, TPL);
      drop_at(DB_HI - 1);
      check(locked == 1'b1, "R4 high band edge quiet", locked, 1);
      check(imax == TPL, "R4 high band edge period", imax, TPL);

      // R5: just below dead band -> shrink, lock drops
      drop_at(DB_LO - 1);
      check(locked == 1'b0, "R7 lock cleared by shrink", locked, 0);
      check(imin == TPL - 1, "R5 shrink period", imin, TPL - 1);
      check(imax == TPL, "R5 shrink max", imax, TPL);

      // R6: just above dead band -> stretch
      drop_at(DB_HI);
      check(imax == TPL + 1, "R6 stretch period", imax, TPL + 1);
      check(imin == TPL, "R6 stretch min", imin, TPL);

      // far phases and frame start/end
      ctag = "R5";
      drop_at(100);
      check(imin == TPL - 1, "R5 early shrink", imin, TPL - 1);
      drop_at(0);
      check(imin == TPL - 1, "R5 shrink at frame start", imin, TPL - 1);
      ctag = "R6";
      drop_at(3000);
      check(imax == TPL + 1, "R6 late stretch", imax, TPL + 1);
      drop_at(FR - 1);
      check(imax == TPL + 1, "R6 stretch at frame end", imax, TPL + 1);
      check(locked == 1'b0, "R7 still unlocked", locked, 0);

      // R7: relock
      ctag = "R7";
      for (int i = 1; i <= LK; i++) begin
         drop_at(HALF + 2);
         check(locked == (i >= LK), "R7 relock", locked, i >= LK);
      end
      check(line_clk_n == ~line_clk, "R2 inverse final", line_clk_n, !line_clk);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule